// File: doc/BRIEF.md
# Peak Hold Monitor with Timed Auto-Clear

This block watches a stream of signed decimated audio samples and keeps two running extremes: the most positive and the most negative value seen since the last clear. Downstream logic reads the two held values to show how close the input comes to full scale.

Both held values return to an empty state when a programmable hold interval runs out. The interval is measured by a 24-bit timebase that advances once per sample-rate enable. A clear fires when the timebase's upper 12 bits are equal to a 12-bit period register that the user loads. One step of the period is 4096 sample periods, which at a 20 kHz sample rate gives roughly 0.2 s per step and about 14 minutes at the top of the range. A period of zero turns the auto-clear off.

Top module: `peak_hold_monitor`

## Requirements
- R1: Synchronous active-low reset sets `pk_max` and `pk_min` to 0 and `clr_pulse` to 0. It also sets the timebase and the period register to 0, and marks the held values as empty.
- R2: The first sample with `smp_vld` high that arrives while the held values are empty loads the same value into both `pk_max` and `pk_min`, one clock after it is presented.
- R3: Later valid samples replace `pk_max` only when they are strictly greater in two's-complement order. An equal or smaller sample leaves it unchanged.
- R4: Later valid samples replace `pk_min` only when they are strictly smaller in two's-complement order. An equal or larger sample leaves it unchanged.
- R5: The timebase advances by one on each clock with `nyq_tick` high and holds otherwise. After a restart, the clear therefore arrives on the (P*4096+1)-th enabled clock, where P is the period.
- R6: A clear happens on an enabled clock where the period P is nonzero and the timebase's upper 12 bits equal P. On the next clock, `clr_pulse` is high for exactly one cycle, both held values read 0 and are empty again, and the timebase restarts at 0.
- R7: When the period register holds 0, no clear ever occurs and the held values persist.
- R8: A clock with `per_wr` high loads `per_val` into the period register and restarts the timebase at 0. A write takes precedence over a clear that would otherwise happen on that clock.
- R9: A valid sample on the same clock as a clear becomes the first sample of the new interval: both held values take that sample, and `clr_pulse` still pulses.
- R10: Samples are accepted on any clock with `smp_vld` high, whether or not `nyq_tick` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| nyq_tick | input | 1 | One-cycle sample-rate enable that advances the timebase |
| smp_vld | input | 1 | Marks `smp_data` as a valid sample |
| smp_data | input | 16 | Signed decimated sample |
| per_wr | input | 1 | Write strobe for the hold-period register |
| per_val | input | 12 | Hold period in units of 4096 sample periods; 0 disables clearing |
| pk_max | output | 16 | Largest signed sample held since the last clear |
| pk_min | output | 16 | Smallest signed sample held since the last clear |
| clr_pulse | output | 1 | One-cycle marker that a timed clear has taken place |

## Verification
If the empty flag is corrupted, the fault appears on the first sample after a clear. When the flag is wrongly cleared, `pk_max` and `pk_min` stay pinned at 0 against a one-sided input. When it is wrongly set, a sample overwrites both extremes. Either error shows on the port one clock after that sample. A timebase that is off by one, or that counts without the enable, moves `clr_pulse` and the zeroing of both outputs by at least one clock. The bench therefore checks the exact clock of every clear, including the cases where a write or a coinciding sample meets the matching enable.

// File: rtl/pkh_pkg.sv
`timescale 1ns/1ps
// Package: pkh_pkg
// Shared defaults and the selector type for the extreme trackers of the
// peak hold monitor. Assumes two's-complement samples throughout.
package pkh_pkg;

    // Default sample width, timebase width and period-register width.
    localparam int unsigned DEF_SMP_W = 16;
    localparam int unsigned DEF_CNT_W = 24;
    localparam int unsigned DEF_PER_W = 12;

    // Which extreme a tracker instance follows.
    typedef enum logic [0:0] {
        TRACK_HI = 1'b0,
        TRACK_LO = 1'b1
    } trk_kind_e;

endpackage

// File: rtl/pkh_timebase.sv
`timescale 1ns/1ps
// Module: pkh_timebase
// Holds the user hold period and a free-running sample-rate timebase.
// It raises `match` combinationally on the enabled clock where the upper
// PER_W bits of the timebase equal a nonzero period. A period write
// restarts the timebase and masks any match on the same clock.
// Assumes CNT_W > PER_W.
module pkh_timebase #(
    parameter int unsigned CNT_W = pkh_pkg::DEF_CNT_W,
    parameter int unsigned PER_W = pkh_pkg::DEF_PER_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             per_wr,
    input  logic [PER_W-1:0] per_in,
    output logic             match,
    output logic [CNT_W-1:0] cnt
);
    localparam int unsigned LO_W = CNT_W - PER_W;

    logic [PER_W-1:0] per_q;
    logic [CNT_W-1:0] cnt_q;
    logic             per_live;
    logic             hi_equal;

    // Decode whether the period is armed and the upper timebase bits match it.
    always_comb begin
        per_live = (per_q != '0);
        hi_equal = (cnt_q[CNT_W-1:LO_W] == per_q);
        match    = tick && !per_wr && per_live && hi_equal;
    end

    // Period register: loaded by a user write only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per_q <= '0;
        end else if (per_wr) begin
            per_q <= per_in;
        end
    end

    // Timebase: restart on write or match, otherwise advance on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (per_wr || match) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt = cnt_q;

endmodule

// File: rtl/pkh_extreme.sv
`timescale 1ns/1ps
// Module: pkh_extreme
// Tracks one extreme (high or low, chosen by KIND) of a signed sample stream.
// `seed` loads the sample unconditionally. `clr` returns the value to zero
// when no sample is present. Otherwise the value moves only on a strictly
// better sample.
module pkh_extreme #(
    parameter int unsigned        SMP_W = pkh_pkg::DEF_SMP_W,
    parameter pkh_pkg::trk_kind_e KIND  = pkh_pkg::TRACK_HI
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    seed,
    input  logic                    clr,
    input  logic                    vld,
    input  logic signed [SMP_W-1:0] din,
    output logic signed [SMP_W-1:0] dout
);
    logic signed [SMP_W-1:0] val_q;
    logic                    better;

    // Pick the strict comparison that matches the tracked extreme.
    generate
        if (KIND == pkh_pkg::TRACK_HI) begin : g_hi
            assign better = (din > val_q);
        end else begin : g_lo
            assign better = (din < val_q);
        end
    endgenerate

    // Held value: seed, then clear, then strictly-better update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            val_q <= '0;
        end else if (vld && seed) begin
            val_q <= din;
        end else if (clr) begin
            val_q <= '0;
        end else if (vld && better) begin
            val_q <= din;
        end
    end

    assign dout = val_q;

endmodule

// File: rtl/peak_hold_monitor.sv
`timescale 1ns/1ps
// Module: peak_hold_monitor
// Holds the signed maximum and minimum of a decimated sample stream. Both
// are cleared after a programmed number of 4096-sample steps. A clear
// restarts the timebase and produces a one-cycle `clr_pulse`.
// Assumes nyq_tick is a single-cycle enable at the sample rate.
module peak_hold_monitor #(
    parameter int unsigned SMP_W = pkh_pkg::DEF_SMP_W,
    parameter int unsigned CNT_W = pkh_pkg::DEF_CNT_W,
    parameter int unsigned PER_W = pkh_pkg::DEF_PER_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    nyq_tick,
    input  logic                    smp_vld,
    input  logic signed [SMP_W-1:0] smp_data,
    input  logic                    per_wr,
    input  logic [PER_W-1:0]        per_val,
    output logic signed [SMP_W-1:0] pk_max,
    output logic signed [SMP_W-1:0] pk_min,
    output logic                    clr_pulse
);
    logic             match_w;
    logic [CNT_W-1:0] cnt_w;
    logic             empty_q;
    logic             clr_q;
    logic             seed_w;

    pkh_timebase #(
        .CNT_W (CNT_W),
        .PER_W (PER_W)
    ) u_tb (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (nyq_tick),
        .per_wr (per_wr),
        .per_in (per_val),
        .match  (match_w),
        .cnt    (cnt_w)
    );

    // A sample seeds both trackers when nothing is held or a clear is due.
    assign seed_w = empty_q || match_w;

    pkh_extreme #(
        .SMP_W (SMP_W),
        .KIND  (pkh_pkg::TRACK_HI)
    ) u_hi (
        .clk   (clk),
        .rst_n (rst_n),
        .seed  (seed_w),
        .clr   (match_w),
        .vld   (smp_vld),
        .din   (smp_data),
        .dout  (pk_max)
    );

    pkh_extreme #(
        .SMP_W (SMP_W),
        .KIND  (pkh_pkg::TRACK_LO)
    ) u_lo (
        .clk   (clk),
        .rst_n (rst_n),
        .seed  (seed_w),
        .clr   (match_w),
        .vld   (smp_vld),
        .din   (smp_data),
        .dout  (pk_min)
    );

    // Empty flag: set by reset or a clear, dropped by any accepted sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            empty_q <= 1'b1;
        end else if (smp_vld) begin
            empty_q <= 1'b0;
        end else if (match_w) begin
            empty_q <= 1'b1;
        end
    end

    // Clear marker: one cycle after the matching enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clr_q <= 1'b0;
        end else begin
            clr_q <= match_w;
        end
    end

    assign clr_pulse = clr_q;

endmodule

// File: rtl/pkh_checker.sv
`timescale 1ns/1ps
// Module: pkh_checker
// Temporal checks for peak_hold_monitor, attached through bind.
module pkh_checker #(
    parameter int unsigned SMP_W = pkh_pkg::DEF_SMP_W,
    parameter int unsigned CNT_W = pkh_pkg::DEF_CNT_W
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    nyq_tick,
    input logic                    smp_vld,
    input logic signed [SMP_W-1:0] smp_data,
    input logic                    per_wr,
    input logic signed [SMP_W-1:0] pk_max,
    input logic signed [SMP_W-1:0] pk_min,
    input logic                    clr_pulse,
    input logic                    empty,
    input logic                    match,
    input logic [CNT_W-1:0]        cnt
);
    // R3 R4: the held extremes never cross
    a_r3_max_not_below_min: assert property (@(posedge clk) disable iff (!rst_n)
        pk_max >= pk_min);

    // R3: while holding and not clearing, the maximum never falls
    a_r3_max_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
        (!empty && !match) |=> pk_max >= $past(pk_max));

    // R4: while holding and not clearing, the minimum never rises
    a_r4_min_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
        (!empty && !match) |=> pk_min <= $past(pk_min));

    // R6: a clear marker follows an enabled clock and lasts one cycle
    a_r6_pulse_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        clr_pulse |-> $past(nyq_tick));

    a_r6_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        clr_pulse |=> !clr_pulse);

    // R6 R9: after a clear the outputs are zero or seeded by a coinciding sample
    a_r9_clear_result: assert property (@(posedge clk) disable iff (!rst_n)
        clr_pulse |-> ((pk_max == '0 && pk_min == '0) ||
                       ($past(smp_vld) && pk_max == $past(smp_data) && pk_min == $past(smp_data))));

    // R8: a period write restarts the timebase and suppresses the clear
    a_r8_write_restart: assert property (@(posedge clk) disable iff (!rst_n)
        per_wr |=> (cnt == '0 && !clr_pulse));

    // R5: without an enable or write the timebase holds
    a_r5_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!nyq_tick && !per_wr) |=> $stable(cnt));

endmodule

bind peak_hold_monitor pkh_checker #(
    .SMP_W (SMP_W),
    .CNT_W (CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .nyq_tick  (nyq_tick),
    .smp_vld   (smp_vld),
    .smp_data  (smp_data),
    .per_wr    (per_wr),
    .pk_max    (pk_max),
    .pk_min    (pk_min),
    .clr_pulse (clr_pulse),
    .empty     (empty_q),
    .match     (match_w),
    .cnt       (cnt_w)
);

// File: tb/sim_peak_hold_monitor.sv
`timescale 1ns/1ps
module sim_peak_hold_monitor;
    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               nyq_tick = 1'b0;
    logic               smp_vld = 1'b0;
    logic signed [15:0] smp_data = '0;
    logic               per_wr = 1'b0;
    logic [11:0]        per_val = '0;
    logic signed [15:0] pk_max;
    logic signed [15:0] pk_min;
    logic               clr_pulse;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        logic signed [15:0] mx;
        logic signed [15:0] mn;
        logic               clr;
        string              tag;
    } exp_t;

    exp_t sb[$];

    // reference state
    logic signed [15:0] m_max = '0;
    logic signed [15:0] m_min = '0;
    bit                 m_empty = 1'b1;
    logic [23:0]        m_cnt = '0;
    logic [11:0]        m_per = '0;

    always #2.5 clk = ~clk;

    peak_hold_monitor u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .nyq_tick  (nyq_tick),
        .smp_vld   (smp_vld),
        .smp_data  (smp_data),
        .per_wr    (per_wr),
        .per_val   (per_val),
        .pk_max    (pk_max),
        .pk_min    (pk_min),
        .clr_pulse (clr_pulse)
    );

    // Driver: apply one clock of stimulus, predict the result, push it.
    task automatic step(input bit vld, input logic signed [15:0] d, input bit tk,
                        input bit wr, input logic [11:0] wv, input string tag);
        bit m;
        exp_t e;
        @(negedge clk);
        smp_vld = vld; smp_data = d; nyq_tick = tk; per_wr = wr; per_val = wv;
        m = tk && !wr && (m_per != 0) && (m_cnt[23:12] == m_per);
        if (wr) begin m_per = wv; m_cnt = '0; end
        else if (tk) m_cnt = m ? '0 : m_cnt + 1'b1;
        if (vld && (m_empty || m)) begin m_max = d; m_min = d; m_empty = 1'b0; end
        else if (m) begin m_max = '0; m_min = '0; m_empty = 1'b1; end
        else if (vld) begin
            if (d > m_max) m_max = d;
            if (d < m_min) m_min = d;
        end
        e.mx = m_max; e.mn = m_min; e.clr = m; e.tag = tag;
        @(posedge clk);
        #1;
        sb.push_back(e);
    endtask

    task automatic ticks(input int n, input string tag);
        for (int i = 0; i < n; i++) step(1'b0, '0, 1'b1, 1'b0, '0, tag);
    endtask

    // Monitor: compare design outputs against the oldest expectation.
    initial begin
        forever begin
            @(negedge clk);
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                checks++;
                if (pk_max !== e.mx || pk_min !== e.mn || clr_pulse !== e.clr) begin
                    failures++;
                    $display("FAIL %s: max=%0d min=%0d clr=%0b expected max=%0d min=%0d clr=%0b",
                             e.tag, pk_max, pk_min, clr_pulse, e.mx, e.mn, e.clr);
                end
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        checks++;
        if (pk_max !== 16'sd0 || pk_min !== 16'sd0 || clr_pulse !== 1'b0) begin
            failures++;
            $display("FAIL R1: max=%0d min=%0d clr=%0b expected 0 0 0", pk_max, pk_min, clr_pulse);
        end
        @(negedge clk);
        rst_n = 1'b1;

        // R2 first sample seeds both; R10 samples accepted without tick
        step(1'b1, 16'sd100, 1'b0, 1'b0, '0, "R2");
        step(1'b1, 16'sd50, 1'b0, 1'b0, '0, "R4");
        step(1'b1, 16'sd300, 1'b0, 1'b0, '0, "R3");
        step(1'b1, -16'sd200, 1'b1, 1'b0, '0, "R10");
        step(1'b1, 16'sd300, 1'b0, 1'b0, '0, "R3");
        step(1'b1, -16'sd200, 1'b0, 1'b0, '0, "R4");
        step(1'b1, 16'sd299, 1'b0, 1'b0, '0, "R3");
        step(1'b1, -16'sd32768, 1'b0, 1'b0, '0, "R4");
        step(1'b1, 16'sd32767, 1'b0, 1'b0, '0, "R3");
        step(1'b0, 16'sd32767, 1'b1, 1'b0, '0, "R3");

        // R7 zero period: many ticks, nothing clears
        ticks(9000, "R7");

        // R8 write period 1, R5 ticks with gaps
        step(1'b0, '0, 1'b0, 1'b1, 12'd1, "R8");
        step(1'b1, 16'sd5, 1'b0, 1'b0, '0, "R10");
        ticks(2000, "R5");
        for (int i = 0; i < 20; i++) step(1'b0, '0, 1'b0, 1'b0, '0, "R5");
        ticks(2200, "R6");
        step(1'b1, -16'sd5, 1'b0, 1'b0, '0, "R2");
        step(1'b1, 16'sd7, 1'b1, 1'b0, '0, "R3");

        // R9 sample on the clearing tick
        step(1'b0, '0, 1'b0, 1'b1, 12'd1, "R8");
        ticks(4096, "R5");
        step(1'b1, 16'sd77, 1'b1, 1'b0, '0, "R9");
        step(1'b1, 16'sd80, 1'b0, 1'b0, '0, "R9");

        // R8 write wins over the matching tick
        step(1'b0, '0, 1'b0, 1'b1, 12'd1, "R8");
        ticks(4096, "R5");
        step(1'b0, '0, 1'b1, 1'b1, 12'd1, "R8");
        ticks(4097, "R6");
        ticks(3, "R6");

        // period 2
        step(1'b1, -16'sd1, 1'b0, 1'b1, 12'd2, "R8");
        ticks(8193, "R6");
        ticks(2, "R6");

        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule